// File: doc/BRIEF.md
# Instruction Decoder with Immediate Prefix

This block turns fixed-size 32-bit instruction words of a small RISC core into decoded fields: operation code, destination register, two source register indices, a format flag, a 32-bit operand immediate, a register-write enable, an illegal-opcode flag and a no-op flag. Words arrive with a valid strobe. All results appear together on registered outputs one clock after the word is accepted.

Two encodings exist. The register-register form names a destination and two sources. The register-immediate form names a destination, one source and a 16-bit constant. A dedicated prefix instruction stores its 16-bit constant as the upper half of the next immediate and arms a pending flag. The next register-immediate instruction then takes `{upper, imm16}` as its operand instead of sign extending. A flush input drops the pending prefix and the word presented in the same cycle. Register file access, execution and memory access lie outside the block.

Top module: `insn_decoder`

## Requirements
- R1: Fields are taken from fixed positions: operation code bits [31:26], destination bits [25:21], first source bits [20:16], second source bits [15:11], immediate bits [15:0].
- R2: Opcode bit 3 selects the format (1 = register-immediate, reported on `out_is_imm`). A register-immediate word reports second source 0. A register-register word reports immediate 0.
- R3: With no pending prefix, a register-immediate word yields its 16-bit immediate sign-extended to 32 bits, with `out_imm_pfx` low.
- R4: A register-immediate word that follows a pending prefix yields `{prefix_imm16, imm16}`, raises `out_imm_pfx` and clears the pending state.
- R5: A register-register word accepted while a prefix is pending clears the pending state, so a later register-immediate word is sign-extended.
- R6: While `flush` is high, the word presented is discarded (no `out_valid` in the next cycle) and any pending prefix is dropped.
- R7: The prefix opcode is 6'b101100. It raises `out_nop`, holds `out_wr_en` low and reports its own immediate sign-extended.
- R8: Legal opcodes are 6'b000000–6'b001111, 6'b100000–6'b100011, 6'b101000–6'b101011, 6'b110000, 6'b110001, 6'b111000, 6'b111001 and the prefix. Any other opcode raises `out_illegal`, reports `out_is_imm` 0, immediate 0 and `out_wr_en` 0, and clears a pending prefix.
- R9: An accepted word produces `out_valid` on the next clock edge. With `in_valid` low, `out_valid` is low one cycle later. Back-to-back words each produce one result.
- R10: After reset, `out_valid`, `out_illegal`, `out_nop` and `out_wr_en` are 0, and no prefix is pending.
- R11: A prefix accepted while another is pending replaces the stored upper half and keeps the pending state. It reports `out_imm_pfx` 0 itself.
- R12: Memory opcodes with bit 0 set (6'b110001, 6'b111001) are stores with `out_wr_en` 0. Every other legal non-prefix opcode has `out_wr_en` 1.
- R13: Cycles with `in_valid` low leave a pending prefix untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard current word and pending prefix |
| in_valid | input | 1 | Instruction word strobe |
| in_word | input | 32 | Instruction word |
| out_valid | output | 1 | Decoded result valid |
| out_op | output | 6 | Operation code |
| out_rd | output | 5 | Destination register index |
| out_ra | output | 5 | First source register index |
| out_rb | output | 5 | Second source register index |
| out_is_imm | output | 1 | Register-immediate format |
| out_imm | output | 32 | Operand immediate |
| out_imm_pfx | output | 1 | Immediate upper half came from a prefix |
| out_illegal | output | 1 | Opcode is not legal |
| out_nop | output | 1 | Prefix word, no register effect |
| out_wr_en | output | 1 | Destination register is written |

## Verification
Every decoded result is due exactly one clock after the edge that accepts its word. Pending-prefix changes also take effect at that same edge, so they show up in the very next accepted word's result. The driver tags each expected item with the cycle in which the word was applied. The monitor samples shortly after each rising edge and requires a popped item's tag to be exactly one cycle old. Any `out_valid` with no item queued counts as a failure, which catches outputs after flushed or idle cycles.

// File: rtl/idec_pkg.sv
package idec_pkg;

    localparam int WORD_W = 32;
    localparam int OP_W   = 6;
    localparam int REG_W  = 5;
    localparam int IMM_W  = 16;

    localparam int OP_LSB  = WORD_W - OP_W;
    localparam int RD_LSB  = OP_LSB - REG_W;
    localparam int RA_LSB  = RD_LSB - REG_W;
    localparam int RB_LSB  = RA_LSB - REG_W;
    localparam int FMT_BIT = 3;
    localparam int UPPER_W = WORD_W - IMM_W;

    typedef enum logic [1:0] {
        CLS_BAD    = 2'd0,
        CLS_ALU    = 2'd1,
        CLS_MEM    = 2'd2,
        CLS_PREFIX = 2'd3
    } insn_class_e;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] ra;
        logic [REG_W-1:0] rb;
        logic [IMM_W-1:0] imm16;
    } fields_t;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [REG_W-1:0]  rd;
        logic [REG_W-1:0]  ra;
        logic [REG_W-1:0]  rb;
        logic              is_imm;
        logic [WORD_W-1:0] imm;
        logic              imm_pfx;
        logic              illegal;
        logic              nop;
        logic              wr_en;
    } decoded_t;

    function automatic insn_class_e op_class(input logic [OP_W-1:0] op,
                                             input logic [OP_W-1:0] pfx_op);
        insn_class_e c;
        c = CLS_BAD;
        if (op == pfx_op)
            c = CLS_PREFIX;
        else if (op[5:4] == 2'b00)
            c = CLS_ALU;
        else if (op[5:4] == 2'b10 && op[2] == 1'b0)
            c = CLS_ALU;
        else if (op[5:4] == 2'b11 && op[2:1] == 2'b00)
            c = CLS_MEM;
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{UPPER_W{v[IMM_W-1]}}, v};
    endfunction

endpackage

// File: rtl/idec_fields.sv
module idec_fields
    import idec_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fields_t           fld
);
    always_comb begin
        fld.op    = word[OP_LSB +: OP_W];
        fld.rd    = word[RD_LSB +: REG_W];
        fld.ra    = word[RA_LSB +: REG_W];
        fld.rb    = word[RB_LSB +: REG_W];
        fld.imm16 = word[IMM_W-1:0];
    end
endmodule

// File: rtl/idec_class.sv
module idec_class
    import idec_pkg::*;
#(
    parameter logic [OP_W-1:0] PREFIX_OP = 6'b101100
) (
    input  logic [OP_W-1:0] op,
    output insn_class_e     cls,
    output logic            is_imm,
    output logic            is_store,
    output logic            writes_rd
);
    always_comb begin
        cls       = op_class(op, PREFIX_OP);
        is_imm    = (cls != CLS_BAD) && op[FMT_BIT];
        is_store  = (cls == CLS_MEM) && op[0];
        writes_rd = (cls == CLS_ALU) || ((cls == CLS_MEM) && !op[0]);
    end
endmodule

// File: rtl/idec_prefix.sv
module idec_prefix
    import idec_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               accept,
    input  logic               is_prefix,
    input  logic [IMM_W-1:0]   imm16,
    output logic               pending,
    output logic [UPPER_W-1:0] upper
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            upper   <= '0;
        end else if (flush) begin
            pending <= 1'b0;
        end else if (accept) begin
            if (is_prefix) begin
                pending <= 1'b1;
                upper   <= imm16[UPPER_W-1:0];
            end else begin
                pending <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
    import idec_pkg::*;
#(
    parameter logic [5:0] PREFIX_OP = 6'b101100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic        in_valid,
    input  logic [31:0] in_word,
    output logic        out_valid,
    output logic [5:0]  out_op,
    output logic [4:0]  out_rd,
    output logic [4:0]  out_ra,
    output logic [4:0]  out_rb,
    output logic        out_is_imm,
    output logic [31:0] out_imm,
    output logic        out_imm_pfx,
    output logic        out_illegal,
    output logic        out_nop,
    output logic        out_wr_en
);
    fields_t            fld;
    insn_class_e        cls;
    logic               is_imm, is_store, writes_rd;
    logic               accept;
    logic               pending;
    logic [UPPER_W-1:0] upper;
    decoded_t           dec;
    decoded_t           dec_q;

    assign accept = in_valid && !flush;

    idec_fields u_fields (
        .word (in_word),
        .fld  (fld)
    );

    idec_class #(.PREFIX_OP(PREFIX_OP)) u_class (
        .op        (fld.op),
        .cls       (cls),
        .is_imm    (is_imm),
        .is_store  (is_store),
        .writes_rd (writes_rd)
    );

    idec_prefix u_prefix (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .accept    (accept),
        .is_prefix (cls == CLS_PREFIX),
        .imm16     (fld.imm16),
        .pending   (pending),
        .upper     (upper)
    );

    always_comb begin
        dec.op      = fld.op;
        dec.rd      = fld.rd;
        dec.ra      = fld.ra;
        dec.rb      = is_imm ? '0 : fld.rb;
        dec.is_imm  = is_imm;
        dec.illegal = (cls == CLS_BAD);
        dec.nop     = (cls == CLS_PREFIX);
        dec.wr_en   = writes_rd && !is_store;
        dec.imm_pfx = 1'b0;
        dec.imm     = '0;
        if (is_imm) begin
            if (pending && cls != CLS_PREFIX) begin
                dec.imm     = {upper, fld.imm16};
                dec.imm_pfx = 1'b1;
            end else begin
                dec.imm = sext_imm(fld.imm16);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            dec_q     <= '0;
        end else begin
            out_valid <= accept;
            if (accept)
                dec_q <= dec;
        end
    end

    assign out_op      = dec_q.op;
    assign out_rd      = dec_q.rd;
    assign out_ra      = dec_q.ra;
    assign out_rb      = dec_q.rb;
    assign out_is_imm  = dec_q.is_imm;
    assign out_imm     = dec_q.imm;
    assign out_imm_pfx = dec_q.imm_pfx;
    assign out_illegal = dec_q.illegal;
    assign out_nop     = dec_q.nop;
    assign out_wr_en   = dec_q.wr_en;
endmodule

// File: rtl/idec_checker.sv
module idec_checker (
    input logic        clk,
    input logic        rst,
    input logic        flush,
    input logic        in_valid,
    input logic [31:0] in_word,
    input logic        out_valid,
    input logic [5:0]  out_op,
    input logic [4:0]  out_rd,
    input logic [4:0]  out_ra,
    input logic [4:0]  out_rb,
    input logic        out_is_imm,
    input logic [31:0] out_imm,
    input logic        out_imm_pfx,
    input logic        out_illegal,
    input logic        out_nop,
    input logic        out_wr_en
);
    p_latency_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !flush) |=> out_valid);

    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_flush_drop_r6: assert property (@(posedge clk) disable iff (rst)
        flush |=> !out_valid);

    p_flush_no_pfx_r6: assert property (@(posedge clk) disable iff (rst)
        flush |=> ##1 !(out_valid && out_imm_pfx));

    p_prefix_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_nop) |-> !out_wr_en && !out_imm_pfx);

    p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_illegal) |-> !out_wr_en && !out_nop && !out_is_imm);

    p_pfx_needs_imm_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_imm_pfx) |-> out_is_imm);

    p_sign_ext_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_is_imm && !out_imm_pfx)
            |-> out_imm[31:16] == {16{out_imm[15]}});

    p_rr_shape_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_is_imm) |-> out_imm == 32'd0);

    p_ri_shape_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_is_imm) |-> out_rb == 5'd0);
endmodule

bind insn_decoder idec_checker u_chk (.*);

// File: tb/tb_insn_decoder.sv
module tb_insn_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic [5:0]  out_op;
    logic [4:0]  out_rd, out_ra, out_rb;
    logic        out_is_imm;
    logic [31:0] out_imm;
    logic        out_imm_pfx, out_illegal, out_nop, out_wr_en;

    insn_decoder dut (.*);

    always #5 clk = ~clk;

    typedef struct {
        int          cyc;
        string       req;
        logic [5:0]  op;
        logic [4:0]  rd, ra, rb;
        logic        is_imm;
        logic [31:0] imm;
        logic        pfx, ill, nop, wr;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    logic m_pend = 1'b0;
    logic [15:0] m_upper = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rr(input logic [5:0] op, input logic [4:0] d,
                                       input logic [4:0] a, input logic [4:0] b);
        return {op, d, a, b, 11'h5A5};
    endfunction

    function automatic logic [31:0] ri(input logic [5:0] op, input logic [4:0] d,
                                       input logic [4:0] a, input logic [15:0] k);
        return {op, d, a, k};
    endfunction

    // Reference built from the requirement text
    task automatic drive(input logic [31:0] w, input logic v, input logic f,
                         input string req);
        exp_t e;
        logic [5:0] op;
        logic legal, pre, store, mem;
        @(negedge clk);
        in_word  = w;
        in_valid = v;
        flush    = f;
        op    = w[31:26];
        pre   = (op == 6'b101100);
        mem   = (op == 6'b110000) || (op == 6'b110001) || (op == 6'b111000) || (op == 6'b111001);
        legal = pre || mem || (op <= 6'b001111) ||
                (op >= 6'b100000 && op <= 6'b100011) || (op >= 6'b101000 && op <= 6'b101011);
        store = mem && op[0];
        if (f) begin
            m_pend = 1'b0;
        end else if (v) begin
            e.cyc = cyc; e.req = req;
            e.op = op; e.rd = w[25:21]; e.ra = w[20:16];
            e.is_imm = legal && op[3];
            e.rb  = e.is_imm ? 5'd0 : w[15:11];
            e.ill = !legal; e.nop = pre;
            e.wr  = legal && !pre && !store;
            e.pfx = 1'b0; e.imm = 32'd0;
            if (e.is_imm) begin
                if (m_pend && !pre) begin
                    e.imm = {m_upper, w[15:0]}; e.pfx = 1'b1;
                end else begin
                    e.imm = {{16{w[15]}}, w[15:0]};
                end
            end
            exp_q.push_back(e);
            if (pre) begin m_pend = 1'b1; m_upper = w[15:0]; end
            else m_pend = 1'b0;
        end
    endtask

    // Monitor (scoreboard)
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst && out_valid) begin
                if (exp_q.size() == 0) begin
                    chk("R6/R9", "unexpected out_valid", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk({e.req, " R9"}, "latency", cyc - e.cyc, 1);
                    chk({e.req, " R1"}, "op", {26'd0, out_op}, {26'd0, e.op});
                    chk({e.req, " R1"}, "rd/ra", {22'd0, out_rd, out_ra}, {22'd0, e.rd, e.ra});
                    chk({e.req, " R2"}, "rb", {27'd0, out_rb}, {27'd0, e.rb});
                    chk({e.req, " R2"}, "is_imm", {31'd0, out_is_imm}, {31'd0, e.is_imm});
                    chk(e.req, "imm", out_imm, e.imm);
                    chk(e.req, "imm_pfx", {31'd0, out_imm_pfx}, {31'd0, e.pfx});
                    chk({e.req, " R8"}, "illegal", {31'd0, out_illegal}, {31'd0, e.ill});
                    chk({e.req, " R7"}, "nop", {31'd0, out_nop}, {31'd0, e.nop});
                    chk({e.req, " R12"}, "wr_en", {31'd0, out_wr_en}, {31'd0, e.wr});
                end
            end
        end
    end

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        chk("R10", "out_valid", {31'd0, out_valid}, 32'd0);
        chk("R10", "flags", {28'd0, out_illegal, out_nop, out_wr_en, out_imm_pfx}, 32'd0);

        // R1 R2: register-register, back-to-back (R9)
        drive(rr(6'b000010, 5'd3, 5'd7, 5'd31), 1, 0, "R1");
        drive(rr(6'b100011, 5'd31, 5'd0, 5'd16), 1, 0, "R2");
        // R10: no pending prefix after reset, so sign extension
        drive(ri(6'b001000, 5'd1, 5'd2, 16'h8001), 1, 0, "R3 R10");
        drive(ri(6'b101010, 5'd4, 5'd5, 16'h1234), 1, 0, "R3");
        // R7 then R4
        drive(ri(6'b101100, 5'd9, 5'd9, 16'hABCD), 1, 0, "R7");
        drive(ri(6'b001011, 5'd6, 5'd8, 16'h8001), 1, 0, "R4");
        drive(ri(6'b001011, 5'd6, 5'd8, 16'h8002), 1, 0, "R4 consumed");
        // R5
        drive(ri(6'b101100, 5'd0, 5'd0, 16'h5555), 1, 0, "R7");
        drive(rr(6'b000001, 5'd2, 5'd3, 5'd4), 1, 0, "R5");
        drive(ri(6'b001000, 5'd2, 5'd3, 16'hF000), 1, 0, "R5");
        // R6: flush with a word present
        drive(ri(6'b101100, 5'd0, 5'd0, 16'h7777), 1, 0, "R7");
        drive(ri(6'b001000, 5'd1, 5'd1, 16'h0042), 1, 1, "R6");
        drive(ri(6'b001000, 5'd1, 5'd1, 16'h8042), 1, 0, "R6");
        drive(32'd0, 0, 1, "R6");
        // R8
        drive(rr(6'b010000, 5'd1, 5'd2, 5'd3), 1, 0, "R8");
        drive(ri(6'b101100, 5'd0, 5'd0, 16'h1111), 1, 0, "R7");
        drive(ri(6'b111111, 5'd1, 5'd2, 16'h00FF), 1, 0, "R8");
        drive(ri(6'b001100, 5'd1, 5'd2, 16'h9000), 1, 0, "R8");
        drive(rr(6'b101101, 5'd1, 5'd2, 5'd3), 1, 0, "R8");
        // R11
        drive(ri(6'b101100, 5'd0, 5'd0, 16'h1111), 1, 0, "R11");
        drive(ri(6'b101100, 5'd0, 5'd0, 16'h2222), 1, 0, "R11");
        drive(ri(6'b101001, 5'd7, 5'd7, 16'h3333), 1, 0, "R11");
        // R12
        drive(rr(6'b110001, 5'd8, 5'd9, 5'd10), 1, 0, "R12");
        drive(ri(6'b111001, 5'd8, 5'd9, 16'hFFFC), 1, 0, "R12");
        drive(rr(6'b110000, 5'd8, 5'd9, 5'd10), 1, 0, "R12");
        drive(ri(6'b111000, 5'd8, 5'd9, 16'h0010), 1, 0, "R12");
        // R13: idle cycles keep the prefix
        drive(ri(6'b101100, 5'd0, 5'd0, 16'hCAFE), 1, 0, "R13");
        for (int i = 0; i < 3; i++) drive(32'hFFFF_FFFF, 0, 0, "R13");
        drive(ri(6'b001111, 5'd30, 5'd29, 16'h0001), 1, 0, "R13");
        drive(32'd0, 0, 0, "R9");
        repeat (3) @(negedge clk);
        chk("R9", "queue drained", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule